// File: doc/BRIEF.md
# Victim-Retaining Micro-TLB

This block is a small fully associative translation cache that sits in front of a larger, low-associativity main TLB. One instance serves instruction fetch and another serves data accesses; the two differ only in the `ENTRIES` parameter (8 for data, 4 for instruction). A lookup that matches a stored entry returns the physical page combinationally, in the same cycle, from flops.

On a miss the block raises a refill request toward the main TLB. The request carries the page number and address-space identifier it needs, and the requester holds its lookup stable until the response arrives. The returned entry is installed into an empty slot if one exists, and otherwise into the slot named by a round-robin pointer.

Entries are deliberately not kept inclusive with the main TLB. A stored translation stays usable after the main array replaces its own copy, so the wider associativity here can hide conflict thrashing in a 2-way main array. The only way to remove entries is the `flush_all` pulse. The main TLB raises that pulse for an ordinary write or an explicit flush command, and does not raise it for its no-flush write kind.

Top module: `utlb_cache`

## Requirements
- R1: A lookup hits when a valid entry has an equal virtual page number and either an equal address-space identifier or its global flag set. The hit and the physical page appear in the same cycle. An entry that is not global does not hit for a different identifier.
- R2: A lookup that misses while no refill is outstanding raises `rf_req` from the next cycle. `rf_vpn` and `rf_asid` carry the lookup's values, and all three hold steady until `rf_valid` is seen.
- R3: An accepted refill response is installed at that clock edge, so the held lookup hits with the returned page in the following cycle.
- R4: While any slot is empty, an installation goes to the lowest-indexed empty slot and never displaces a valid entry.
- R5: When all slots are valid, installations replace slots in round-robin order starting at index 0 after reset.
- R6: A valid entry stays valid for any number of cycles unless `flush_all` is pulsed. This covers the case where the main TLB has since replaced its own copy through a write that does not flush.
- R7: A `flush_all` pulse invalidates every entry at that clock edge, so every previously stored translation misses afterward.
- R8: If `flush_all` arrives while a refill is outstanding, the response that follows is discarded. The held lookup then misses and issues a fresh refill request.
- R9: `rf_req` falls in the cycle after the refill response is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | One-cycle pulse that invalidates all entries |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_hit | output | 1 | Lookup matched a valid entry this cycle |
| lk_ppn | output | PPN_W | Physical page of the matching entry (zero on a miss) |
| rf_req | output | 1 | Refill request toward the main TLB |
| rf_vpn | output | VPN_W | Page number being requested |
| rf_asid | output | ASID_W | Identifier being requested |
| rf_valid | input | 1 | Refill response present |
| rf_ppn | input | PPN_W | Returned physical page |
| rf_global | input | 1 | Returned entry matches every identifier |

## Verification
`lk_hit` and `lk_ppn` are combinational, so the bench drives a lookup just after a falling edge and samples it a quarter period later, before the next rising edge. `rf_req` rises one edge after a missing lookup and falls one edge after the response. An installed or flushed entry becomes visible one edge after `rf_valid` or `flush_all`. The bench therefore applies each stimulus on a falling edge and checks the registered result after the following rising edge has passed. Round-robin order is checked by filling every slot, adding two more entries, and probing which of the original pages miss.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
   // Refill sequencer states
   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,  // no refill outstanding
      FS_WAIT = 2'd1,  // refill outstanding, response will be installed
      FS_DROP = 2'd2   // refill outstanding, response will be discarded
   } fill_state_e;
endpackage

// File: rtl/utlb_match.sv
module utlb_match #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic [ENTRIES-1:0]             valid,
   input  logic [ENTRIES-1:0]             glob,
   input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn,
   input  logic [ENTRIES-1:0][ASID_W-1:0] asid,
   input  logic [ENTRIES-1:0][PPN_W-1:0]  ppn,
   input  logic [VPN_W-1:0]               key_vpn,
   input  logic [ASID_W-1:0]              key_asid,
   output logic [ENTRIES-1:0]             hit_vec,
   output logic [PPN_W-1:0]               hit_ppn
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      logic vpn_eq, asid_ok;
      assign vpn_eq     = (vpn[i] == key_vpn);
      assign asid_ok    = glob[i] | (asid[i] == key_asid);
      assign hit_vec[i] = valid[i] & vpn_eq & asid_ok;
   end

   always_comb begin
      hit_ppn = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (hit_vec[i]) hit_ppn = hit_ppn | ppn[i];
   end
endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
   parameter int ENTRIES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid,
   input  logic               advance,
   output logic [ENTRIES-1:0] sel
);
   localparam int PTR_W = $clog2(ENTRIES);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

   logic [PTR_W-1:0]   ptr_q;
   logic [ENTRIES-1:0] free_sel;
   logic               any_free;

   always_comb begin
      free_sel = '0;
      any_free = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!valid[i] && !any_free) begin
            free_sel[i] = 1'b1;
            any_free    = 1'b1;
         end
      end
   end

   always_comb begin
      if (any_free) sel = free_sel;
      else          sel = ENTRIES'(1) << ptr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       ptr_q <= '0;
      else if (advance) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
   end

   // R4: an empty slot is always preferred over a valid one
   p_victim_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (~&valid) |-> ((sel & valid) == '0));
   // R5: exactly one slot is chosen
   p_victim_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(sel));
   // R5: the pointer moves only when the table is full
   p_ptr_only_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (~&valid) |=> $stable(ptr_q));
endmodule

// File: rtl/utlb_cache.sv
module utlb_cache
   import utlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_all,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              lk_hit,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic              rf_req,
   output logic [VPN_W-1:0]  rf_vpn,
   output logic [ASID_W-1:0] rf_asid,
   input  logic              rf_valid,
   input  logic [PPN_W-1:0]  rf_ppn,
   input  logic              rf_global
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("utlb_cache: ENTRIES must be at least 2");
   end
   if (VPN_W < 1 || PPN_W < 1 || ASID_W < 1) begin : g_bad_width
      $error("utlb_cache: field widths must be positive");
   end

   logic [ENTRIES-1:0]             valid_q, glob_q;
   logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
   logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
   logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
   logic [ENTRIES-1:0]             hit_vec, victim;
   logic [PPN_W-1:0]               hit_ppn;
   fill_state_e                    state_q;
   logic                           install, table_full;

   utlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) u_match (
      .valid(valid_q), .glob(glob_q), .vpn(vpn_q), .asid(asid_q), .ppn(ppn_q),
      .key_vpn(lk_vpn), .key_asid(lk_asid), .hit_vec(hit_vec), .hit_ppn(hit_ppn)
   );

   assign table_full = &valid_q;
   assign install    = (state_q == FS_WAIT) && rf_valid && !flush_all;

   utlb_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk(clk), .rst_n(rst_n), .valid(valid_q),
      .advance(install && table_full), .sel(victim)
   );

   assign lk_hit = lk_valid && (|hit_vec);
   assign lk_ppn = lk_hit ? hit_ppn : '0;
   assign rf_req = (state_q != FS_IDLE);

   // Refill sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         rf_vpn  <= '0;
         rf_asid <= '0;
      end else begin
         unique case (state_q)
            FS_IDLE: if (lk_valid && !(|hit_vec)) begin
               state_q <= FS_WAIT;
               rf_vpn  <= lk_vpn;
               rf_asid <= lk_asid;
            end
            FS_WAIT: if (rf_valid)       state_q <= FS_IDLE;
                     else if (flush_all) state_q <= FS_DROP;
            FS_DROP: if (rf_valid)       state_q <= FS_IDLE;
            default:                     state_q <= FS_IDLE;
         endcase
      end
   end

   // Entry storage
   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[i] <= 1'b0;
         end else if (flush_all) begin
            valid_q[i] <= 1'b0;
         end else if (install && victim[i]) begin
            valid_q[i] <= 1'b1;
         end
      end
      always_ff @(posedge clk) begin
         if (install && victim[i]) begin
            vpn_q[i]  <= rf_vpn;
            asid_q[i] <= rf_asid;
            ppn_q[i]  <= rf_ppn;
            glob_q[i] <= rf_global;
         end
      end
   end

   // R2: request and its key stay put until answered
   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_req && !rf_valid) |=> (rf_req && $stable(rf_vpn) && $stable(rf_asid)));
   // R3: an accepted response leaves at least one valid entry
   p_install_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FS_WAIT && rf_valid && !flush_all) |=> (|valid_q));
   // R6: no entry loses its valid bit without a flush
   p_retain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !flush_all |=> ((valid_q & $past(valid_q)) == $past(valid_q)));
   // R7: a flush empties the table
   p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (valid_q == '0));
   // R8: a discarded response changes no entry
   p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FS_DROP && rf_valid && !flush_all) |=> $stable(valid_q));
   // R9: request falls after the response
   p_req_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_req && rf_valid) |=> !rf_req);
endmodule

// File: tb/tb_utlb_cache.sv
module tb_utlb_cache;
   localparam int ENTRIES = 8;
   localparam int VPN_W = 20, PPN_W = 20, ASID_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush_all = 1'b0;
   logic lk_valid = 1'b0;
   logic [VPN_W-1:0] lk_vpn = '0;
   logic [ASID_W-1:0] lk_asid = '0;
   logic lk_hit;
   logic [PPN_W-1:0] lk_ppn;
   logic rf_req;
   logic [VPN_W-1:0] rf_vpn;
   logic [ASID_W-1:0] rf_asid;
   logic rf_valid = 1'b0;
   logic [PPN_W-1:0] rf_ppn = '0;
   logic rf_global = 1'b0;

   int n_run = 0, n_fail = 0;

   always #10 clk = ~clk; // 50 MHz

   utlb_cache #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) dut (
      .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
      .lk_hit(lk_hit), .lk_ppn(lk_ppn),
      .rf_req(rf_req), .rf_vpn(rf_vpn), .rf_asid(rf_asid),
      .rf_valid(rf_valid), .rf_ppn(rf_ppn), .rf_global(rf_global)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; lk_valid = 1'b0; rf_valid = 1'b0; flush_all = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Combinational probe: never lets a miss reach a rising edge
   task automatic probe(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                        input bit exp_hit, input logic [PPN_W-1:0] exp_ppn, input string tag);
      @(negedge clk);
      lk_valid = 1'b1; lk_vpn = v; lk_asid = a;
      #5;
      chk(lk_hit == exp_hit, tag, 32'(lk_hit), 32'(exp_hit));
      if (exp_hit) chk(lk_ppn == exp_ppn, tag, 32'(lk_ppn), 32'(exp_ppn));
      lk_valid = 1'b0;
   endtask

   // Miss, request, response, hit
   task automatic miss_fill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                            input logic [PPN_W-1:0] p, input bit g);
      @(negedge clk);
      lk_valid = 1'b1; lk_vpn = v; lk_asid = a;
      #5;
      chk(!lk_hit, "R2 miss before fill", 32'(lk_hit), 0);
      @(negedge clk);
      chk(rf_req, "R2 request raised", 32'(rf_req), 1);
      chk(rf_vpn == v, "R2 request vpn", 32'(rf_vpn), 32'(v));
      chk(rf_asid == a, "R2 request asid", 32'(rf_asid), 32'(a));
      @(negedge clk);
      chk(rf_req, "R2 request held", 32'(rf_req), 1);
      rf_valid = 1'b1; rf_ppn = p; rf_global = g;
      @(negedge clk);
      rf_valid = 1'b0;
      #5;
      chk(lk_hit, "R3 hit after fill", 32'(lk_hit), 1);
      chk(lk_ppn == p, "R3 returned page", 32'(lk_ppn), 32'(p));
      chk(!rf_req, "R9 request dropped", 32'(rf_req), 0);
      lk_valid = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      #5;
      chk(!rf_req, "R9 reset no request", 32'(rf_req), 0);
      probe(20'h00000, 8'h00, 1'b0, '0, "R7 reset empty");
   endtask

   task automatic t_match();
      do_reset();
      miss_fill(20'h00A10, 8'h05, 20'h7A001, 1'b0);
      probe(20'h00A10, 8'h05, 1'b1, 20'h7A001, "R1 exact hit");
      probe(20'h00A10, 8'h06, 1'b0, '0, "R1 other asid misses");
      probe(20'h00A11, 8'h05, 1'b0, '0, "R1 other vpn misses");
      miss_fill(20'h00B20, 8'h05, 20'h7B002, 1'b1);
      probe(20'h00B20, 8'h99, 1'b1, 20'h7B002, "R1 global any asid");
   endtask

   task automatic t_replace();
      do_reset();
      for (int i = 0; i < ENTRIES; i++)
         miss_fill(20'h00100 + 20'(i), 8'h01, 20'h50000 + 20'(i), 1'b0);
      for (int i = 0; i < ENTRIES; i++)
         probe(20'h00100 + 20'(i), 8'h01, 1'b1, 20'h50000 + 20'(i), "R4 empty slots used first");
      miss_fill(20'h00200, 8'h01, 20'h60000, 1'b0);
      probe(20'h00100, 8'h01, 1'b0, '0, "R5 slot0 replaced first");
      probe(20'h00101, 8'h01, 1'b1, 20'h50001, "R5 slot1 kept");
      miss_fill(20'h00201, 8'h01, 20'h60001, 1'b0);
      probe(20'h00101, 8'h01, 1'b0, '0, "R5 slot1 replaced second");
      probe(20'h00102, 8'h01, 1'b1, 20'h50002, "R5 slot2 kept");
      probe(20'h00200, 8'h01, 1'b1, 20'h60000, "R5 new entry present");
   endtask

   task automatic t_retain();
      do_reset();
      miss_fill(20'h00C00, 8'h07, 20'h3C000, 1'b0);
      repeat (60) @(negedge clk);
      probe(20'h00C00, 8'h07, 1'b1, 20'h3C000, "R6 entry retained");
   endtask

   task automatic t_flush();
      do_reset();
      miss_fill(20'h00D00, 8'h02, 20'h1D000, 1'b0);
      miss_fill(20'h00D01, 8'h02, 20'h1D001, 1'b1);
      @(negedge clk); flush_all = 1'b1;
      @(negedge clk); flush_all = 1'b0;
      probe(20'h00D00, 8'h02, 1'b0, '0, "R7 flushed entry 0");
      probe(20'h00D01, 8'h02, 1'b0, '0, "R7 flushed global entry");
   endtask

   task automatic t_flush_pending();
      do_reset();
      @(negedge clk);
      lk_valid = 1'b1; lk_vpn = 20'h00E00; lk_asid = 8'h03;
      @(negedge clk);
      chk(rf_req, "R8 request pending", 32'(rf_req), 1);
      flush_all = 1'b1;
      @(negedge clk);
      flush_all = 1'b0;
      rf_valid = 1'b1; rf_ppn = 20'h2E000; rf_global = 1'b0;
      @(negedge clk);
      rf_valid = 1'b0;
      #5;
      chk(!lk_hit, "R8 stale refill discarded", 32'(lk_hit), 0);
      @(negedge clk);
      chk(rf_req, "R8 fresh request", 32'(rf_req), 1);
      rf_valid = 1'b1; rf_ppn = 20'h2E111;
      @(negedge clk);
      rf_valid = 1'b0;
      #5;
      chk(lk_hit && lk_ppn == 20'h2E111, "R8 retry hit", 32'(lk_ppn), 32'h2E111);
      lk_valid = 1'b0;
   endtask

   initial begin
      t_reset();
      t_match();
      t_replace();
      t_retain();
      t_flush();
      t_flush_pending();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule